// File: doc/BRIEF.md
# System Clock Control Unit

This block sits on a byte-wide register bus of a small microcontroller and decides how the system clock is derived. It holds two control registers and a one-bit write lock. From their contents it produces a system clock enable taken from either the main oscillator or the subclock oscillator. The main oscillator path can be divided by 1, 2, 4, 8 or 16. The block also drives the select for the clock output pin, a wait-mode gate for the peripheral clock, and the stop and drive-strength controls of both oscillators.

The oscillators are modelled as single-cycle tick inputs on the block clock, each with a ready flag. Setting the stop bit halts every clock enable and forces some control bits to 1. A wake input later clears the stop bit. Clock enables resume once the main oscillator reports ready, and the divider restarts from zero.

Register map on `addr`: 0 is control register A, 1 is control register B, 2 is the lock register (only bit 0 is stored), and 3 reads as zero. Reads are combinational on `rd_data`. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, control register A reads 0x48, control register B reads 0x20 and the lock register reads 0x00.
- R2: A write to register A or register B is ignored unless bit 0 of the lock register is 1. The lock register itself can always be written.
- R3: Bits 4:1 of register B always read 0, whatever value is written to them.
- R4: `clkout_mode` equals bits 1:0 of register A. The encoding is 00 general I/O, 01 undivided main clock, 10 divide-by-8 clock, 11 divide-by-32 clock.
- R5: When the main source is selected, `sys_ce` pulses on every Nth main tick, and the first pulse after reset or restart comes on tick N. N is 8 when bit 6 of register A is 1. Otherwise N is taken from bits 7:6 of register B: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 16.
- R6: When bit 7 of register A is 1, each enabled subclock tick produces one `sys_ce` pulse and main ticks produce none.
- R7: A write that would change bit 7 of register A from 0 to 1 leaves the bit at 0 unless bit 4 is already 1 and `sub_ready` is high. A write that would change it from 1 to 0 leaves it at 1 unless bit 5 is already 0 and `main_ready` is high. The other bits of that write still take effect.
- R8: `main_osc_stop` equals bit 5 of register A, and while it is 1 main ticks are ignored. `sub_osc_en` equals bit 4 of register A, and subclock ticks count only while it is 1.
- R9: Writing 1 to bit 0 of register B enters stop mode. `stop_mode` goes high and `sys_ce`, `periph_run` and `f32_run` are held low. Register A bits 6 and 3 and register B bit 5 are forced to 1 at the same edge.
- R10: A `wake` pulse in stop mode clears bit 0 of register B. Clock enables stay off until `main_ready` is seen high. The divider then restarts, so the first `sys_ce` pulse comes a full period after enables resume.
- R11: While `wait_mode` is high and bit 2 of register A is 1, `periph_run` is low. `f32_run` is not affected by this gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| main_tick | input | 1 | Main oscillator tick, one cycle wide |
| main_ready | input | 1 | Main oscillator stable |
| sub_tick | input | 1 | Subclock oscillator tick, one cycle wide |
| sub_ready | input | 1 | Subclock oscillator stable |
| wake | input | 1 | Wake-up request out of stop mode |
| wait_mode | input | 1 | Processor is in wait mode |
| sys_ce | output | 1 | System clock enable pulse |
| periph_run | output | 1 | Peripheral clock enable level |
| f32_run | output | 1 | Subclock-derived peripheral clock enable level |
| clkout_mode | output | 2 | Clock output pin function select |
| main_osc_stop | output | 1 | Main oscillator stop control |
| sub_osc_en | output | 1 | Subclock oscillator pins enable |
| sub_drive_hi | output | 1 | Subclock drive strength high |
| main_drive_hi | output | 1 | Main drive strength high |
| stop_mode | output | 1 | Stop mode active |

## Verification
The bound checker checks the following on every cycle:
- the lock gate on register A writes;
- the reserved bits of register B staying zero;
- the refusal of a source switch to an unready subclock;
- the forced bits at stop entry;
- the silence of all clock enables during stop;
- the wait-mode peripheral gate.

Some behaviour can only be shown by the bench's directed scenarios, because it needs a count over a tick sequence. This covers:
- the pulse spacing for each division ratio;
- the position of the first pulse after reset and after wake-up;
- the hold on enables until the main oscillator reports ready;
- subclock pass-through, and the rejection of a switch back to a stopped or unready main oscillator.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTLA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTLB = 2'd1;
  localparam logic [ADDR_W-1:0] A_LOCK = 2'd2;

  localparam logic [DATA_W-1:0] CTLA_RST = 8'h48;
  localparam logic [DATA_W-1:0] CTLB_RST = 8'h20;
  localparam logic [DATA_W-1:0] CTLB_KEEP = 8'hE1; // reserved bits 4:1 cleared

  // register A bit positions
  localparam int A_WGATE = 2;
  localparam int A_SDRV  = 3;
  localparam int A_SUBEN = 4;
  localparam int A_MSTOP = 5;
  localparam int A_DIV8  = 6;
  localparam int A_SRC   = 7;
  // register B bit positions
  localparam int B_STOP  = 0;
  localparam int B_MDRV  = 5;
endpackage

// File: rtl/sysclk_rst_sync.sv
module sysclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              main_ready,
  input  logic              sub_ready,
  input  logic              wake,
  output logic [DATA_W-1:0] ctla,
  output logic [DATA_W-1:0] ctlb,
  output logic              lock_open,
  output logic              hold
);
  logic [DATA_W-1:0] ctla_n, ctlb_n;
  logic              lock_n, hold_n;
  logic              sub_ok, main_ok;

  assign sub_ok  = ctla[A_SUBEN] & sub_ready;
  assign main_ok = ~ctla[A_MSTOP] & main_ready;

  always_comb begin
    ctla_n = ctla;
    ctlb_n = ctlb;
    lock_n = lock_open;
    hold_n = hold;

    if (wr_en) begin
      unique case (addr)
        A_LOCK: lock_n = wr_data[0];
        A_CTLA: if (lock_open) begin
          ctla_n = wr_data;
          if (wr_data[A_SRC] && !ctla[A_SRC] && !sub_ok)  ctla_n[A_SRC] = 1'b0;
          if (!wr_data[A_SRC] && ctla[A_SRC] && !main_ok) ctla_n[A_SRC] = 1'b1;
        end
        A_CTLB: if (lock_open) begin
          ctlb_n = wr_data & CTLB_KEEP;
          if (wr_data[B_STOP] && !ctlb[B_STOP]) begin
            ctlb_n[B_MDRV] = 1'b1;
            ctla_n[A_DIV8] = 1'b1;
            ctla_n[A_SDRV] = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (hold && main_ready) hold_n = 1'b0;

    if (ctlb[B_STOP] && wake) begin
      ctlb_n[B_STOP] = 1'b0;
      hold_n         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla      <= CTLA_RST;
      ctlb      <= CTLB_RST;
      lock_open <= 1'b0;
      hold      <= 1'b0;
    end else begin
      ctla      <= ctla_n;
      ctlb      <= ctlb_n;
      lock_open <= lock_n;
      hold      <= hold_n;
    end
  end
endmodule

// File: rtl/sysclk_div.sv
module sysclk_div #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] last,
  output logic             ce
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             at_end;

  assign at_end = (cnt_q >= last);
  assign ce     = tick & at_end & ~clr;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)       cnt_n = '0;
    else if (tick) cnt_n = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int DIV_W      = 4,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              main_tick,
  input  logic              main_ready,
  input  logic              sub_tick,
  input  logic              sub_ready,
  input  logic              wake,
  input  logic              wait_mode,
  output logic              sys_ce,
  output logic              periph_run,
  output logic              f32_run,
  output logic [1:0]        clkout_mode,
  output logic              main_osc_stop,
  output logic              sub_osc_en,
  output logic              sub_drive_hi,
  output logic              main_drive_hi,
  output logic              stop_mode
);
  logic              rst_n_s;
  logic [DATA_W-1:0] ctla, ctlb;
  logic              lock_open, hold, run;
  logic              main_g, sub_g, src_tick, div_ce;
  logic [DIV_W-1:0]  div_last;

  sysclk_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  sysclk_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .main_ready(main_ready), .sub_ready(sub_ready), .wake(wake),
    .ctla(ctla), .ctlb(ctlb), .lock_open(lock_open), .hold(hold)
  );

  always_comb begin
    if (ctla[A_SRC])       div_last = '0;
    else if (ctla[A_DIV8]) div_last = DIV_W'(7);
    else begin
      unique case (ctlb[7:6])
        2'b00: div_last = '0;
        2'b01: div_last = DIV_W'(1);
        2'b10: div_last = DIV_W'(3);
        default: div_last = DIV_W'(15);
      endcase
    end
  end

  assign main_g   = main_tick & ~ctla[A_MSTOP];
  assign sub_g    = sub_tick & ctla[A_SUBEN];
  assign src_tick = ctla[A_SRC] ? sub_g : main_g;
  assign run      = ~ctlb[B_STOP] & ~hold;

  sysclk_div #(.CNT_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .clr(~run), .tick(src_tick),
    .last(div_last), .ce(div_ce)
  );

  assign sys_ce        = run & div_ce;
  assign f32_run       = run;
  assign periph_run    = run & ~(wait_mode & ctla[A_WGATE]);
  assign clkout_mode   = ctla[1:0];
  assign main_osc_stop = ctla[A_MSTOP];
  assign sub_osc_en    = ctla[A_SUBEN];
  assign sub_drive_hi  = ctla[A_SDRV];
  assign main_drive_hi = ctlb[B_MDRV];
  assign stop_mode     = ctlb[B_STOP];

  always_comb begin
    unique case (addr)
      A_CTLA:  rd_data = ctla;
      A_CTLB:  rd_data = ctlb;
      A_LOCK:  rd_data = {{(DATA_W-1){1'b0}}, lock_open};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk
  import sysclk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ctla,
  input logic [DATA_W-1:0] ctlb,
  input logic              lock_open,
  input logic              sub_ready,
  input logic              wait_mode,
  input logic              sys_ce,
  input logic              periph_run,
  input logic              f32_run,
  input logic              stop_mode
);
  assert_locked_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTLA && !lock_open) |=> $stable(ctla));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctlb[4:1] == 4'b0000);

  assert_sub_switch_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTLA && lock_open && wr_data[A_SRC] && !ctla[A_SRC]
     && !(ctla[A_SUBEN] && sub_ready)) |=> !ctla[A_SRC]);

  assert_stop_forces_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_mode) |-> (ctla[A_DIV8] && ctla[A_SDRV] && ctlb[B_MDRV]));

  assert_stop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> (!sys_ce && !periph_run && !f32_run));

  assert_wait_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && ctla[A_WGATE]) |-> !periph_run);
endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .ctla(ctla), .ctlb(ctlb), .lock_open(lock_open), .sub_ready(sub_ready),
  .wait_mode(wait_mode), .sys_ce(sys_ce), .periph_run(periph_run),
  .f32_run(f32_run), .stop_mode(stop_mode)
);

// File: tb/sysclk_ctrl_test.sv
module sysclk_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, main_tick, main_ready, sub_tick, sub_ready, wake, wait_mode;
  logic [1:0] addr;
  logic [7:0] wr_data, rd_data;
  logic       sys_ce, periph_run, f32_run, main_osc_stop, sub_osc_en;
  logic       sub_drive_hi, main_drive_hi, stop_mode;
  logic [1:0] clkout_mode;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  sysclk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .main_tick(main_tick), .main_ready(main_ready),
    .sub_tick(sub_tick), .sub_ready(sub_ready), .wake(wake), .wait_mode(wait_mode),
    .sys_ce(sys_ce), .periph_run(periph_run), .f32_run(f32_run),
    .clkout_mode(clkout_mode), .main_osc_stop(main_osc_stop), .sub_osc_en(sub_osc_en),
    .sub_drive_hi(sub_drive_hi), .main_drive_hi(main_drive_hi), .stop_mode(stop_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  // n ticks on one source; returns index of first sys_ce and pulse count
  task automatic run_ticks(input bit use_sub, input int n, output int first, output int cnt);
    first = 0; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (use_sub) sub_tick = 1'b1; else main_tick = 1'b1;
      #2;
      if (sys_ce) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    @(negedge clk);
    main_tick = 1'b0; sub_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d; int f, c;
    rd(2'd0, d); chk("R1 ctlA reset", d, 8'h48);
    rd(2'd1, d); chk("R1 ctlB reset", d, 8'h20);
    rd(2'd2, d); chk("R1 lock reset", d, 8'h00);
    chk("R4 clkout reset", clkout_mode, 0);
    run_ticks(0, 16, f, c);
    chk("R5 div8 first", f, 8);
    chk("R5 div8 count", c, 2);
  endtask

  task automatic t_lock_div();
    logic [7:0] d; int f, c;
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R2 locked write ignored", d, 8'h48);
    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R2 lock open", d, 8'h01);
    wr(2'd1, 8'h5E);
    rd(2'd1, d); chk("R3 reserved read zero", d, 8'h40);
    run_ticks(0, 8, f, c);
    chk("R5 div8 overrides field", f, 8);
    wr(2'd0, 8'h01);
    chk("R4 clkout fC", clkout_mode, 1);
    run_ticks(0, 8, f, c);
    chk("R5 div2 first", f, 2); chk("R5 div2 count", c, 4);
    wr(2'd1, 8'h80);
    run_ticks(0, 8, f, c);
    chk("R5 div4 first", f, 4); chk("R5 div4 count", c, 2);
    wr(2'd1, 8'hC0);
    run_ticks(0, 16, f, c);
    chk("R5 div16 first", f, 16); chk("R5 div16 count", c, 1);
    wr(2'd1, 8'h00);
    run_ticks(0, 5, f, c);
    chk("R5 div1 count", c, 5);
  endtask

  task automatic t_clkout();
    wr(2'd0, 8'h03); chk("R4 clkout f32", clkout_mode, 3);
    wr(2'd0, 8'h02); chk("R4 clkout f8", clkout_mode, 2);
  endtask

  task automatic t_source();
    logic [7:0] d; int f, c;
    sub_ready = 1'b0;
    wr(2'd0, 8'h92);
    rd(2'd0, d); chk("R7 switch to unready sub refused", d, 8'h12);
    chk("R8 sub enable out", sub_osc_en, 1);
    sub_ready = 1'b1;
    wr(2'd0, 8'h92);
    rd(2'd0, d); chk("R7 switch to ready sub", d, 8'h92);
    run_ticks(0, 4, f, c); chk("R6 main ticks ignored on sub", c, 0);
    run_ticks(1, 3, f, c); chk("R6 sub ticks pass", c, 3);
    wr(2'd0, 8'hB2);
    chk("R8 main stop out", main_osc_stop, 1);
    wr(2'd0, 8'h32);
    rd(2'd0, d); chk("R7 switch to stopped main refused", d, 8'hB2);
    wr(2'd0, 8'h92);
    main_ready = 1'b0;
    wr(2'd0, 8'h12);
    rd(2'd0, d); chk("R7 switch to unready main refused", d, 8'h92);
    main_ready = 1'b1;
    wr(2'd0, 8'h12);
    rd(2'd0, d); chk("R7 switch to ready main", d, 8'h12);
    wr(2'd0, 8'h32);
    run_ticks(0, 4, f, c); chk("R8 stopped main gives no ce", c, 0);
  endtask

  task automatic t_wait();
    wr(2'd0, 8'h16);
    @(negedge clk); wait_mode = 1'b1; #1;
    chk("R11 periph gated", periph_run, 0);
    chk("R11 f32 kept", f32_run, 1);
    @(negedge clk); wait_mode = 1'b0; #1;
    chk("R11 periph runs outside wait", periph_run, 1);
    wr(2'd0, 8'h12);
    @(negedge clk); wait_mode = 1'b1; #1;
    chk("R11 no gate when bit clear", periph_run, 1);
    @(negedge clk); wait_mode = 1'b0;
  endtask

  task automatic t_stop();
    logic [7:0] d; int f, c;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    rd(2'd0, d); chk("R9 ctlA before stop", d, 8'h00);
    wr(2'd1, 8'h41);
    rd(2'd1, d); chk("R9 ctlB forced", d, 8'h61);
    rd(2'd0, d); chk("R9 ctlA forced", d, 8'h48);
    chk("R9 stop out", stop_mode, 1);
    chk("R9 sub drive out", sub_drive_hi, 1);
    chk("R9 main drive out", main_drive_hi, 1);
    chk("R9 periph off", periph_run, 0);
    chk("R9 f32 off", f32_run, 0);
    run_ticks(0, 8, f, c); chk("R9 no ce in stop", c, 0);
    main_ready = 1'b0;
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    rd(2'd1, d); chk("R10 wake clears stop", d, 8'h60);
    run_ticks(0, 8, f, c); chk("R10 held until ready", c, 0);
    chk("R10 periph held", periph_run, 0);
    main_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 periph resumes", periph_run, 1);
    run_ticks(0, 16, f, c);
    chk("R10 first pulse full period", f, 8);
    chk("R10 count", c, 2);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
    main_tick = 1'b0; sub_tick = 1'b0; main_ready = 1'b1; sub_ready = 1'b0;
    wake = 1'b0; wait_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_lock_div();
    t_clkout();
    t_source();
    t_wait();
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule